// File: doc/BRIEF.md
# Dual-Mode Watchdog / Interval Timer

This peripheral counts upward on an 8-bit counter that is fed by a prescaler. The prescaler divides the input clock by one of eight powers of two. Software configures the timer through an 8-bit control/status register on a small synchronous register bus with read and write strobes, a one-bit address, a 16-bit write-data word and a combinational 8-bit read-data word. Each write carries a key byte in the upper half of the data word, and a write with a wrong key is dropped. This guards the control/status register and the counter against stray stores.

In interval mode, a counter wrap from 0xFF to 0x00 latches a sticky status flag, and the interrupt request output follows that flag. In watchdog mode, a wrap never touches the flag. It produces a one-cycle pulse on a dedicated overflow output instead, and logic outside the block can turn that pulse into a reset. Software clears the flag with a two-step handshake: it reads the register and sees the flag at 1, then writes 0 to that bit.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the control/status register reads 0x18, the counter reads 0x00, and both `irq_o` and `wdog_ovf_o` are low.
- R2: Address 0 selects the control/status register. Its bits read back as follows: bit 7 is the overflow flag, bit 6 is the mode (0 interval, 1 watchdog), bit 5 is the enable, bits 4 and 3 always read 1, and bits 2:0 are the clock select.
- R3: A write to address 0 takes effect only when `bus_wdata_i[15:8]` is 0xA5. A write to address 1 takes effect only when `bus_wdata_i[15:8]` is 0x5A. A write carrying any other key changes nothing.
- R4: While the enable bit is 0, the counter and the prescaler are held at zero, and keyed writes to the counter are ignored.
- R5: Clock-select values 0 through 7 give divide ratios N of 2, 64, 128, 512, 2048, 8192, 32768 and 131072. The counter first advances on the N-th rising edge after the edge that sets the enable bit, and again every N edges after that.
- R6: A keyed counter write loads `bus_wdata_i[7:0]` into the counter. It wins over an advance in the same cycle and does not shift the prescaler phase.
- R7: In interval mode, a counter step from 0xFF to 0x00 sets the overflow flag, and `irq_o` is high exactly while the flag is 1.
- R8: In watchdog mode, a wrap leaves the flag unchanged and drives `wdog_ovf_o` high for exactly one cycle, in the cycle after the wrap edge.
- R9: The flag clears only through a keyed register write with bit 7 at 0 that follows a read of the register that returned bit 7 at 1. Writing 1 to bit 7, or writing 0 without that prior read, leaves the flag set.
- R10: `bus_rdata_o` shows the addressed register in the same cycle, and a read has no effect other than arming the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 1 | 0 selects the control/status register, 1 selects the counter |
| bus_wdata_i | input | 16 | Key byte in bits 15:8, value in bits 7:0 |
| bus_rdata_o | output | 8 | Addressed register contents |
| irq_o | output | 1 | Interval interrupt request, follows the flag |
| wdog_ovf_o | output | 1 | One-cycle watchdog overflow pulse |

## Verification
The embedded properties assume that the strobes are synchronous to the clock and that a read and a write never fall in the same cycle. They also assume the address and data are steady whenever a strobe is high. The stimulus changes every input on the falling clock edge and issues exactly one bus operation per cycle. The expected count at each read is derived from the number of rising edges since the enabling write and from any counter load. The disable step before each new clock select restarts the prescaler phase from a known zero.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    localparam logic [7:0] CSR_KEY   = 8'hA5;
    localparam logic [7:0] CNT_KEY   = 8'h5A;

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_WATCHDOG = 1'b1
    } tmr_mode_e;

    // Control/status state plus the clear-handshake and pulse bits
    typedef struct packed {
        logic      flag;
        tmr_mode_e mode;
        logic      en;
        logic [2:0] cks;
        logic      armed;
        logic      pulse;
    } csr_state_t;

    // Log2 of the divide ratio for each clock-select code
    function automatic int tap_shift(input int sel);
        case (sel)
            0:       return 1;
            1:       return 6;
            2:       return 7;
            3:       return 9;
            4:       return 11;
            5:       return 13;
            6:       return 15;
            default: return 17;
        endcase
    endfunction

endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler
    import dmt_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int PRE_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    localparam int TAPS = 1 << SEL_W;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_d, st_q;

    logic [PRE_W-1:0] mask_tbl [TAPS];
    logic [PRE_W-1:0] sel_mask;

    // One low-order mask per divide ratio
    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        assign mask_tbl[g] = {PRE_W{1'b1}} >> (PRE_W - SH);
    end

    assign sel_mask = mask_tbl[sel_i];
    assign tick_o   = run_i && ((st_q.pre & sel_mask) == sel_mask);

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRESCALER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (st_q.pre == '0)); // R4

endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign cnt_o  = st_q.cnt;
    assign wrap_o = run_i && tick_i && !load_i && (st_q.cnt == CNT_MAX);

    always_comb begin
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_o == '0)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && load_i) |=> (cnt_o == $past(load_val_i))); // R6
    AST_WRAP_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> (cnt_o == '0)); // R7

endmodule

// File: rtl/dmt_csr.sv
module dmt_csr
    import dmt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    input  logic       rd_i,
    input  logic       wrap_i,
    output logic [7:0] csr_o,
    output logic       en_o,
    output logic [2:0] cks_o,
    output logic       flag_o,
    output logic       pulse_o
);

    csr_state_t st_d, st_q;
    logic       unused_rsv;

    assign unused_rsv = ^wdata_i[4:3];

    assign csr_o   = {st_q.flag, st_q.mode, st_q.en, 2'b11, st_q.cks};
    assign en_o    = st_q.en;
    assign cks_o   = st_q.cks;
    assign flag_o  = st_q.flag;
    assign pulse_o = st_q.pulse;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        // A read that sees the flag arms the clear
        if (rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (wr_i) begin
            st_d.mode  = tmr_mode_e'(wdata_i[6]);
            st_d.en    = wdata_i[5];
            st_d.cks   = wdata_i[2:0];
            if (!wdata_i[7] && st_q.armed) begin
                st_d.flag = 1'b0;
            end
            st_d.armed = 1'b0;
        end
        // Overflow event has priority over a clear
        if (wrap_i) begin
            if (st_q.mode == MODE_INTERVAL) begin
                st_d.flag = 1'b1;
            end else begin
                st_d.pulse = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{flag: 1'b0, mode: MODE_INTERVAL, en: 1'b0, cks: 3'd0,
                      armed: 1'b0, pulse: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    AST_FLAG_INTERVAL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.flag) |-> ($past(st_q.mode) == MODE_INTERVAL)); // R7
    AST_NO_FLAG_IN_WDOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wrap_i && st_q.mode == MODE_WATCHDOG && !st_q.flag) |=> !st_q.flag); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pulse |=> !st_q.pulse); // R8
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.flag) |-> $past(wr_i && st_q.armed && !wdata_i[7])); // R9

endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
    import dmt_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int BUS_W = 16,
    parameter int SEL_W = 3,
    parameter int PRE_W = 17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_wr_i,
    input  logic             bus_rd_i,
    input  logic             bus_addr_i,
    input  logic [BUS_W-1:0] bus_wdata_i,
    output logic [REG_W-1:0] bus_rdata_o,
    output logic             irq_o,
    output logic             wdog_ovf_o
);

    localparam int CNT_W   = REG_W;
    localparam int KEY_LSB = BUS_W - 8;

    logic [7:0]       key;
    logic             csr_wr, cnt_wr, csr_rd;
    logic [7:0]       csr_val;
    logic             en;
    logic [2:0]       cks;
    logic             flag;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    assign key    = bus_wdata_i[BUS_W-1:KEY_LSB];
    assign csr_wr = bus_wr_i && !bus_addr_i && (key == CSR_KEY);
    assign cnt_wr = bus_wr_i &&  bus_addr_i && (key == CNT_KEY);
    assign csr_rd = bus_rd_i && !bus_addr_i;

    dmt_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (en),
        .sel_i  (cks[SEL_W-1:0]),
        .tick_o (tick)
    );

    dmt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (en),
        .tick_i     (tick),
        .load_i     (cnt_wr),
        .load_val_i (bus_wdata_i[CNT_W-1:0]),
        .cnt_o      (cnt),
        .wrap_o     (wrap)
    );

    dmt_csr u_csr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (csr_wr),
        .wdata_i (bus_wdata_i[7:0]),
        .rd_i    (csr_rd),
        .wrap_i  (wrap),
        .csr_o   (csr_val),
        .en_o    (en),
        .cks_o   (cks),
        .flag_o  (flag),
        .pulse_o (wdog_ovf_o)
    );

    assign bus_rdata_o = bus_addr_i ? cnt : csr_val;
    assign irq_o       = flag;

    AST_BAD_KEY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && !bus_addr_i && key != CSR_KEY) |=> $stable(csr_val[6:0])); // R3

endmodule

// File: tb/tb_dual_mode_timer.sv
`timescale 1ns/1ps
module tb_dual_mode_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq;
    logic        wdog_ovf;

    int checks = 0;
    int fails = 0;
    int edge_cnt = 0;
    int pulse_cnt = 0;
    int mark = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) edge_cnt++;

    dual_mode_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (bus_wr),
        .bus_rd_i    (bus_rd),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq),
        .wdog_ovf_o  (wdog_ovf)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data and compares away from the edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (wdog_ovf) pulse_cnt++;
            if (bus_rd) begin
                if (exp_q.size() == 0) begin
                    check("R10 unexpected read", 1, 0);
                end else begin
                    check(tag_q.pop_front(), int'(bus_rdata), int'(exp_q.pop_front()));
                end
            end
        end
    end

    task automatic wr(input logic addr, input logic [7:0] key, input logic [7:0] val);
        bus_wr = 1'b1; bus_addr = addr; bus_wdata = {key, val};
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic addr, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = addr;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] cnt_model(input int v, input int mw, input int n);
        int m;
        m = edge_cnt - mark;
        return 8'((v + m / n - mw / n) & 255);
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int mw;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset values
        rd_expect(1'b0, 8'h18, "R1 csr reset");
        rd_expect(1'b1, 8'h00, "R1 counter reset");
        check("R1 irq reset", int'(irq), 0);
        check("R1 pulse reset", int'(wdog_ovf), 0);

        // R3 wrong keys
        wr(1'b0, 8'h00, 8'h27);
        rd_expect(1'b0, 8'h18, "R3 csr zero key");
        wr(1'b0, 8'h5A, 8'h27);
        rd_expect(1'b0, 8'h18, "R3 csr counter key");

        // R4 counter load while disabled
        wr(1'b1, 8'h5A, 8'h33);
        rd_expect(1'b1, 8'h00, "R4 load ignored when disabled");
        idle(10);
        rd_expect(1'b1, 8'h00, "R4 held at zero");

        // R5 divide by 2, interval mode
        wr(1'b0, 8'hA5, 8'h20);
        mark = edge_cnt;
        rd_expect(1'b0, 8'h38, "R2 csr enabled interval");
        idle(5);
        rd_expect(1'b1, cnt_model(0, 0, 2), "R5 div2 early");
        idle(40);
        rd_expect(1'b1, cnt_model(0, 0, 2), "R5 div2 later");

        // R6 counter load, R3 wrong counter key
        wr(1'b1, 8'h5A, 8'hF8);
        mw = edge_cnt - mark;
        rd_expect(1'b1, cnt_model(8'hF8, mw, 2), "R6 loaded value");
        idle(3);
        rd_expect(1'b1, cnt_model(8'hF8, mw, 2), "R6 advance after load");
        check("R7 irq low before wrap", int'(irq), 0);
        wr(1'b1, 8'hA5, 8'h10);
        rd_expect(1'b1, cnt_model(8'hF8, mw, 2), "R3 counter bad key");

        // R7 wrap sets flag
        idle(30);
        check("R7 irq after wrap", int'(irq), 1);
        // R9 clear without a prior read is refused
        wr(1'b0, 8'hA5, 8'h20);
        rd_expect(1'b0, 8'hB8, "R9 clear without read");
        // R9 writing 1 does not clear
        wr(1'b0, 8'hA5, 8'hA0);
        rd_expect(1'b0, 8'hB8, "R9 write one keeps flag");
        check("R7 irq held", int'(irq), 1);
        // R9 proper clear
        wr(1'b0, 8'hA5, 8'h20);
        rd_expect(1'b0, 8'h38, "R9 flag cleared");
        check("R7 irq follows clear", int'(irq), 0);

        // R8 watchdog mode
        wr(1'b0, 8'hA5, 8'h60);
        rd_expect(1'b0, 8'h78, "R2 csr watchdog");
        pulse_cnt = 0;
        wr(1'b1, 8'h5A, 8'hFC);
        idle(40);
        check("R8 single pulse", pulse_cnt, 1);
        check("R8 irq stays low", int'(irq), 0);
        rd_expect(1'b0, 8'h78, "R8 flag not set");

        // R5 other ratios, prescaler restarted by disable
        wr(1'b0, 8'hA5, 8'h00);
        idle(1);
        rd_expect(1'b1, 8'h00, "R4 cleared on disable");
        wr(1'b0, 8'hA5, 8'h21);
        mark = edge_cnt;
        idle(200);
        rd_expect(1'b1, cnt_model(0, 0, 64), "R5 div64");

        wr(1'b0, 8'hA5, 8'h00);
        idle(1);
        wr(1'b0, 8'hA5, 8'h22);
        mark = edge_cnt;
        idle(300);
        rd_expect(1'b1, cnt_model(0, 0, 128), "R5 div128");

        wr(1'b0, 8'hA5, 8'h00);
        idle(1);
        wr(1'b0, 8'hA5, 8'h23);
        mark = edge_cnt;
        idle(1100);
        rd_expect(1'b1, cnt_model(0, 0, 512), "R5 div512");

        wr(1'b0, 8'hA5, 8'h00);
        idle(1);
        wr(1'b0, 8'hA5, 8'h24);
        mark = edge_cnt;
        idle(4200);
        rd_expect(1'b1, cnt_model(0, 0, 2048), "R5 div2048");

        idle(2);
        check("R10 all reads compared", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule